// File: doc/BRIEF.md
# Paged 32-bit Register Bridge for a 16-bit Management Port

This block is a management-port slave that opens a 32-bit internal register space to a host that can only issue 16-bit accesses addressed by a PHY address and a register number. The serial framing of the management interface is decoded elsewhere. The bridge sees one strobe per access, with the PHY address, the register number, the write data and a read or write flag.

The 16-bit internal word index is built from three sources. A page register supplies the upper 9 bits, and it is loaded through one reserved management location. Bits 2:0 of the PHY address supply the next 3 bits. Register-number bits 4:1 supply the lowest 4 bits. Register-number bit 0 selects the low or the high half of the 32-bit word.

The two halves are paired so that every internal access is atomic:
- **Writes:** the host writes the high half first, and the bridge only holds it. The following low-half write issues one 32-bit internal write.
- **Reads:** the host reads the low half first. That read performs one 32-bit internal read and keeps the upper 16 bits. The following high-half read returns the kept bits.

The internal bus is a plain combinational strobe interface. Its read data is expected in the same cycle as the read strobe.

Top module: `mdio_page_bridge`

## Requirements
- R1: After reset the page is 0, and the management read data output is 0xFFFF.
- R2: A write to PHY address 0x1F, register 0x10 loads bits 8:0 of the write data into the page. A read of that location returns the page zero-extended to 16 bits, in the cycle after the read strobe. Neither access strobes the internal bus.
- R3: A window access is one to PHY addresses 0x10..0x17. For such an access, the internal word index equals {page, PHY address bits 2:0, register-number bits 4:1}.
- R4: A window write with register-number bit 0 = 1 (high half) issues no internal write. It only replaces the held high half, so the last high-half write before a commit is the one used.
- R5: A window write with register-number bit 0 = 0 (low half) issues exactly one internal write strobe in the same cycle. The internal write data is {held high half, write data}.
- R6: A window read of the low half issues exactly one internal read strobe in the same cycle. It returns internal read data bits 15:0 on the management read data in the next cycle, and it keeps bits 31:16.
- R7: A window read of the high half issues no internal read. It returns, in the next cycle, the bits kept by the most recent low-half read, or 0 if there has been no such read since reset.
- R8: An access to any other PHY address, or to PHY 0x1F at any register other than 0x10, strobes nothing. Such a read returns 0xFFFF, and such a write leaves the page unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mgmt_phy | input | 5 | PHY address of the current access |
| mgmt_reg | input | 5 | Register number of the current access |
| mgmt_wdata | input | 16 | Management write data |
| mgmt_we | input | 1 | Write strobe, one cycle per access |
| mgmt_re | input | 1 | Read strobe, one cycle per access |
| mgmt_rdata | output | 16 | Management read data, valid the cycle after mgmt_re |
| bus_addr | output | 16 | Internal word index |
| bus_wdata | output | 32 | Internal write data |
| bus_we | output | 1 | Internal write strobe |
| bus_re | output | 1 | Internal read strobe |
| bus_rdata | input | 32 | Internal read data, same cycle as bus_re |

## Verification
The bench presents, through its model of the internal bus, read data that is a distinct arithmetic function of every word index. As a result, a wrong page value or a wrong address bit shows at once as wrong data on the very next management read. A corrupted held write half shows as wrong upper write data on the commit strobe that follows it. A stale or missed read capture shows on the next high-half read. In each case the fault is visible within one access of its cause.

// File: rtl/mpb_pkg.sv
package mpb_pkg;

    localparam int PHY_W    = 5;
    localparam int REG_W    = 5;
    localparam int HALF_W   = 16;
    localparam int WORD_W   = 2 * HALF_W;
    localparam int WIN_BITS = 3;
    localparam int IDX_BITS = 4;
    localparam int LOW_W    = WIN_BITS + IDX_BITS;

    localparam logic [PHY_W-1:0] PAGE_PHY = 5'h1F;
    localparam logic [REG_W-1:0] PAGE_REG = 5'h10;
    localparam logic [PHY_W-WIN_BITS-1:0] WIN_TAG = 2'b10;
    localparam logic [HALF_W-1:0] IDLE_READ = 16'hFFFF;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_PAGE = 2'd1,
        ACC_LOW  = 2'd2,
        ACC_HIGH = 2'd3
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e          kind;
        logic [LOW_W-1:0]   low_idx;
    } acc_dec_t;

    function automatic acc_dec_t classify(
        input logic [PHY_W-1:0] phy,
        input logic [REG_W-1:0] rnum
    );
        acc_dec_t d;
        d.low_idx = {phy[WIN_BITS-1:0], rnum[REG_W-1:1]};
        if (phy == PAGE_PHY && rnum == PAGE_REG)
            d.kind = ACC_PAGE;
        else if (phy[PHY_W-1:WIN_BITS] == WIN_TAG)
            d.kind = rnum[0] ? ACC_HIGH : ACC_LOW;
        else
            d.kind = ACC_NONE;
        return d;
    endfunction

endpackage

// File: rtl/mpb_decode.sv
module mpb_decode
    import mpb_pkg::*;
(
    input  logic [PHY_W-1:0] phy,
    input  logic [REG_W-1:0] rnum,
    input  logic             we,
    input  logic             re,
    output acc_kind_e        kind,
    output logic [LOW_W-1:0] low_idx,
    output logic             wr_page,
    output logic             wr_low,
    output logic             wr_high,
    output logic             rd_page,
    output logic             rd_low,
    output logic             rd_high,
    output logic             rd_none
);
    acc_dec_t dec;

    always_comb begin
        dec     = classify(phy, rnum);
        kind    = dec.kind;
        low_idx = dec.low_idx;
        wr_page = we && (dec.kind == ACC_PAGE);
        wr_low  = we && (dec.kind == ACC_LOW);
        wr_high = we && (dec.kind == ACC_HIGH);
        rd_page = re && !we && (dec.kind == ACC_PAGE);
        rd_low  = re && !we && (dec.kind == ACC_LOW);
        rd_high = re && !we && (dec.kind == ACC_HIGH);
        rd_none = re && !we && (dec.kind == ACC_NONE);
    end
endmodule

// File: rtl/mpb_page_reg.sv
module mpb_page_reg #(
    parameter int PAGE_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PAGE_W-1:0] din,
    output logic [PAGE_W-1:0] page
);
    always_ff @(posedge clk) begin
        if (rst)
            page <= '0;
        else if (load)
            page <= din;
    end
endmodule

// File: rtl/mpb_half_pair.sv
module mpb_half_pair
    import mpb_pkg::*;
#(
    parameter int PAGE_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_high,
    input  logic              rd_page,
    input  logic              rd_low,
    input  logic              rd_high,
    input  logic              rd_none,
    input  logic [HALF_W-1:0] wdata,
    input  logic [PAGE_W-1:0] page,
    input  logic [WORD_W-1:0] bus_rdata,
    output logic [HALF_W-1:0] held_wr_hi,
    output logic [HALF_W-1:0] rdata
);
    localparam int PAD_W = HALF_W - PAGE_W;

    logic [HALF_W-1:0] held_rd_hi;
    logic [HALF_W-1:0] page_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            assign page_ext = {{PAD_W{1'b0}}, page};
        end else begin : g_nopad
            assign page_ext = page[HALF_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            held_wr_hi <= '0;
            held_rd_hi <= '0;
            rdata      <= IDLE_READ;
        end else begin
            if (wr_high)
                held_wr_hi <= wdata;
            if (rd_low) begin
                held_rd_hi <= bus_rdata[WORD_W-1:HALF_W];
                rdata      <= bus_rdata[HALF_W-1:0];
            end else if (rd_high) begin
                rdata <= held_rd_hi;
            end else if (rd_page) begin
                rdata <= page_ext;
            end else if (rd_none) begin
                rdata <= IDLE_READ;
            end
        end
    end
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
    import mpb_pkg::*;
#(
    parameter int PAGE_W = 9,
    localparam int ADDR_W = PAGE_W + LOW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PHY_W-1:0]  mgmt_phy,
    input  logic [REG_W-1:0]  mgmt_reg,
    input  logic [HALF_W-1:0] mgmt_wdata,
    input  logic              mgmt_we,
    input  logic              mgmt_re,
    output logic [HALF_W-1:0] mgmt_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    input  logic [WORD_W-1:0] bus_rdata
);
    acc_kind_e         kind;
    logic [LOW_W-1:0]  low_idx;
    logic              wr_page, wr_low, wr_high;
    logic              rd_page, rd_low, rd_high, rd_none;
    logic [PAGE_W-1:0] page_q;
    logic [HALF_W-1:0] held_wr_hi;

    mpb_decode u_dec (
        .phy     (mgmt_phy),
        .rnum    (mgmt_reg),
        .we      (mgmt_we),
        .re      (mgmt_re),
        .kind    (kind),
        .low_idx (low_idx),
        .wr_page (wr_page),
        .wr_low  (wr_low),
        .wr_high (wr_high),
        .rd_page (rd_page),
        .rd_low  (rd_low),
        .rd_high (rd_high),
        .rd_none (rd_none)
    );

    mpb_page_reg #(.PAGE_W(PAGE_W)) u_page (
        .clk  (clk),
        .rst  (rst),
        .load (wr_page),
        .din  (mgmt_wdata[PAGE_W-1:0]),
        .page (page_q)
    );

    mpb_half_pair #(.PAGE_W(PAGE_W)) u_pair (
        .clk        (clk),
        .rst        (rst),
        .wr_high    (wr_high),
        .rd_page    (rd_page),
        .rd_low     (rd_low),
        .rd_high    (rd_high),
        .rd_none    (rd_none),
        .wdata      (mgmt_wdata),
        .page       (page_q),
        .bus_rdata  (bus_rdata),
        .held_wr_hi (held_wr_hi),
        .rdata      (mgmt_rdata)
    );

    assign bus_addr  = {page_q, low_idx};
    assign bus_wdata = {held_wr_hi, mgmt_wdata};
    assign bus_we    = wr_low;
    assign bus_re    = rd_low;

    logic unused_kind;
    assign unused_kind = ^kind;
endmodule

// File: rtl/mpb_checker.sv
module mpb_checker
    import mpb_pkg::*;
#(
    parameter int PAGE_W = 9,
    parameter int ADDR_W = PAGE_W + LOW_W
) (
    input logic              clk,
    input logic              rst,
    input logic [PHY_W-1:0]  mgmt_phy,
    input logic [REG_W-1:0]  mgmt_reg,
    input logic [HALF_W-1:0] mgmt_wdata,
    input logic              mgmt_we,
    input logic              mgmt_re,
    input logic [HALF_W-1:0] mgmt_rdata,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              bus_re,
    input logic [PAGE_W-1:0] page_q
);
    logic in_win, at_page;
    assign in_win  = (mgmt_phy[PHY_W-1:WIN_BITS] == WIN_TAG);
    assign at_page = (mgmt_phy == PAGE_PHY) && (mgmt_reg == PAGE_REG);

    // R2: page location write loads the page
    a_r2_page_load: assert property (@(posedge clk) disable iff (rst)
        (mgmt_we && at_page) |=> (page_q == $past(mgmt_wdata[PAGE_W-1:0])));

    // R3: word index low bits follow the register number
    a_r3_index_low: assert property (@(posedge clk) disable iff (rst)
        (bus_we || bus_re) |-> (bus_addr[IDX_BITS-1:0] == mgmt_reg[REG_W-1:1]));

    // R4: high half write never strobes the bus
    a_r4_high_no_write: assert property (@(posedge clk) disable iff (rst)
        (mgmt_we && in_win && mgmt_reg[0]) |-> !bus_we);

    // R5: bus write only on a low half window write
    a_r5_commit_low: assert property (@(posedge clk) disable iff (rst)
        bus_we |-> (mgmt_we && in_win && !mgmt_reg[0]));

    // R6: bus read only on a low half window read
    a_r6_read_low: assert property (@(posedge clk) disable iff (rst)
        bus_re |-> (mgmt_re && in_win && !mgmt_reg[0]));

    // R8: foreign reads return all ones
    a_r8_idle_read: assert property (@(posedge clk) disable iff (rst)
        (mgmt_re && !mgmt_we && !in_win && !at_page) |=> (mgmt_rdata == IDLE_READ));

    // R8: foreign writes keep the page
    a_r8_page_kept: assert property (@(posedge clk) disable iff (rst)
        (mgmt_we && !at_page) |=> $stable(page_q));
endmodule

bind mdio_page_bridge mpb_checker #(.PAGE_W(PAGE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mgmt_phy   (mgmt_phy),
    .mgmt_reg   (mgmt_reg),
    .mgmt_wdata (mgmt_wdata),
    .mgmt_we    (mgmt_we),
    .mgmt_re    (mgmt_re),
    .mgmt_rdata (mgmt_rdata),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_re     (bus_re),
    .page_q     (page_q)
);

// File: tb/mdio_page_bridge_test.sv
`timescale 1ns/1ps
module mdio_page_bridge_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  mgmt_phy = '0;
    logic [4:0]  mgmt_reg = '0;
    logic [15:0] mgmt_wdata = '0;
    logic        mgmt_we = 1'b0;
    logic        mgmt_re = 1'b0;
    logic [15:0] mgmt_rdata;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_we;
    logic        bus_re;
    logic [31:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;

    logic [15:0] s_addr;
    logic [31:0] s_wdata;
    logic        s_we, s_re;
    logic [15:0] s_rd;

    always #2.5 clk = ~clk;

    function automatic logic [31:0] model_word(input logic [15:0] a);
        return {a ^ 16'h5A3C, a + 16'h1111};
    endfunction

    assign bus_rdata = model_word(bus_addr);

    mdio_page_bridge uut (
        .clk(clk), .rst(rst), .mgmt_phy(mgmt_phy), .mgmt_reg(mgmt_reg),
        .mgmt_wdata(mgmt_wdata), .mgmt_we(mgmt_we), .mgmt_re(mgmt_re),
        .mgmt_rdata(mgmt_rdata), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic re, input logic [4:0] phy,
                          input logic [4:0] rn, input logic [15:0] wd);
        @(negedge clk);
        mgmt_we = we; mgmt_re = re; mgmt_phy = phy; mgmt_reg = rn; mgmt_wdata = wd;
        #1;
        s_addr = bus_addr; s_wdata = bus_wdata; s_we = bus_we; s_re = bus_re;
        @(posedge clk);
        #1;
        s_rd = mgmt_rdata;
        mgmt_we = 1'b0; mgmt_re = 1'b0;
    endtask

    function automatic logic [15:0] idx(input logic [8:0] pg, input logic [4:0] phy,
                                        input logic [4:0] rn);
        return {pg, phy[2:0], rn[4:1]};
    endfunction

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [8:0] pages [3];
        pages[0] = 9'h000; pages[1] = 9'h1FF; pages[2] = 9'h0A5;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        check("R1 reset rdata", {16'h0, mgmt_rdata}, 32'hFFFF);
        access(1'b0, 1'b1, 5'h1F, 5'h10, 16'h0);
        check("R1 reset page", {16'h0, s_rd}, 32'h0);
        access(1'b0, 1'b1, 5'h10, 5'h01, 16'h0);
        check("R7 high before any low read", {16'h0, s_rd}, 32'h0);

        for (int p = 0; p < 3; p++) begin
            access(1'b1, 1'b0, 5'h1F, 5'h10, {7'h55, pages[p]});
            check("R2 page write no bus strobe", {30'h0, s_we, s_re}, 32'h0);
            access(1'b0, 1'b1, 5'h1F, 5'h10, 16'h0);
            check("R2 page readback", {16'h0, s_rd}, {23'h0, pages[p]});
            for (int ph = 0; ph < 32; ph++) begin
                for (int r = 0; r < 32; r += 2) begin
                    logic [15:0] wi;
                    logic [31:0] w;
                    wi = idx(pages[p], 5'(ph), 5'(r));
                    w = model_word(wi);
                    if (ph >= 16 && ph <= 23) begin
                        access(1'b0, 1'b1, 5'(ph), 5'(r), 16'h0);
                        check("R6 single bus read", {31'h0, s_re}, 32'h1);
                        check("R3 word index", {16'h0, s_addr}, {16'h0, wi});
                        check("R6 low half", {16'h0, s_rd}, {16'h0, w[15:0]});
                        access(1'b0, 1'b1, 5'(ph), 5'(r + 1), 16'h0);
                        check("R7 no bus read on high", {31'h0, s_re}, 32'h0);
                        check("R7 high half", {16'h0, s_rd}, {16'h0, w[31:16]});
                    end else if (!(ph == 31 && r == 16)) begin
                        access(1'b0, 1'b1, 5'(ph), 5'(r), 16'h0);
                        check("R8 foreign read strobes", {30'h0, s_re, s_we}, 32'h0);
                        check("R8 foreign read data", {16'h0, s_rd}, 32'hFFFF);
                        access(1'b0, 1'b1, 5'(ph), 5'(r + 1), 16'h0);
                        check("R8 foreign odd read data", {16'h0, s_rd}, 32'hFFFF);
                    end
                end
            end
        end

        access(1'b1, 1'b0, 5'h1F, 5'h10, 16'h0123);
        for (int ph = 16; ph < 24; ph++) begin
            for (int r = 0; r < 32; r += 6) begin
                logic [15:0] hi, lo;
                hi = 16'(ph * 16'h0911 + r);
                lo = 16'(16'hC000 ^ (ph << 5) ^ r);
                access(1'b1, 1'b0, 5'(ph), 5'(r | 1), 16'hDEAD);
                check("R4 high write no strobe", {31'h0, s_we}, 32'h0);
                access(1'b1, 1'b0, 5'(ph), 5'(r | 1), hi);
                check("R4 high write no strobe", {31'h0, s_we}, 32'h0);
                access(1'b1, 1'b0, 5'(ph), 5'(r & 30), lo);
                check("R5 commit strobe", {31'h0, s_we}, 32'h1);
                check("R5 commit data", s_wdata, {hi, lo});
                check("R3 write index", {16'h0, s_addr}, {16'h0, idx(9'h123, 5'(ph), 5'(r & 30))});
            end
        end

        for (int ph = 0; ph < 32; ph++) begin
            if (!(ph >= 16 && ph <= 23)) begin
                access(1'b1, 1'b0, 5'(ph), (ph == 31) ? 5'h11 : 5'h10, 16'h00AA);
                check("R8 foreign write strobe", {31'h0, s_we}, 32'h0);
            end
        end
        access(1'b0, 1'b1, 5'h1F, 5'h10, 16'h0);
        check("R8 page unchanged", {16'h0, s_rd}, 32'h0123);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule